// File: doc/BRIEF.md
# Constant-Time Buffer Equality Comparator

This block decides whether two byte buffers of a programmable length hold the same contents. The block's timing must not reveal where the buffers first differ. A caller pulses `start` together with a length. The block then takes one byte from each buffer per accepted cycle through a valid/ready handshake. It XORs each pair and ORs the result into a running difference byte.

The comparison never ends early. A mismatch in the first pair takes the same number of accepted transfers and the same number of cycles as a mismatch in the last pair, or as no mismatch at all. After the final pair is taken, a one-cycle `done` pulse qualifies two results:

- `diff_out`, the accumulated difference byte.
- `equal`, which is the NOR of that byte.

No branch in the control depends on the data.

Top module: `ct_buf_compare`

## Requirements
- R1: While reset is asserted and right after it, `done` and `pair_ready` are 0 and `diff_out` is 0.
- R2: A `start` pulse with a nonzero length clears `diff_out` to 0 and raises `pair_ready` on the next cycle.
- R3: Each accepted pair (`pair_valid` and `pair_ready` both high at a clock edge) ORs `a_byte ^ b_byte` into `diff_out`, visible on the next cycle.
- R4: `pair_ready` stays high until exactly `length` pairs have been accepted, whether or not a nonzero difference has already appeared.
- R5: `done` is high for exactly one cycle: the cycle after the last pair is accepted. With back-to-back valid pairs, that is `length`+1 cycles after the `start` cycle for any data.
- R6: When `done` is high, `equal` is 1 exactly when the two buffers matched, and `diff_out` is the OR over all pairs of the bytewise XOR.
- R7: A length of 0 raises `done` on the cycle after `start`, with `equal` = 1 and `diff_out` = 0, and accepts no pairs.
- R8: A `start` during a comparison abandons it. The new comparison begins with a cleared difference and the new length. `pair_ready` is low in the `start` cycle.
- R9: While `pair_ready` is low and `start` is low, `pair_valid` and the data inputs have no effect: `diff_out` holds and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a comparison; samples `length` |
| length | input | LEN_W | Number of byte pairs to compare |
| pair_valid | input | 1 | A byte pair is offered |
| a_byte | input | DATA_W | Byte from buffer A |
| b_byte | input | DATA_W | Byte from buffer B |
| pair_ready | output | 1 | Comparator accepts a pair this cycle |
| done | output | 1 | One-cycle result strobe |
| equal | output | 1 | Buffers identical (valid with `done`) |
| diff_out | output | DATA_W | Accumulated difference byte (valid with `done`) |

## Verification
The bench sweeps lengths 0 to 6, with the mismatch placed at every position, no mismatch, and two mismatches. For each case it checks that `done` lands on the same cycle offset. A design that stopped at the first mismatch would raise `done` early and drop `pair_ready` too soon. A design that overwrote instead of ORing would lose an earlier difference when a later pair matched.

Directed cases cover the remaining corners. Zero length must complete in one cycle with `equal` set; a design that waited for a pair would hang. A restart in mid-comparison must clear stale differences. Pairs offered while idle must be ignored; a design that took them would corrupt `diff_out`.

// File: rtl/ct_buf_compare.sv
module ct_buf_compare #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  length,
  input  logic              pair_valid,
  input  logic [DATA_W-1:0] a_byte,
  input  logic [DATA_W-1:0] b_byte,
  output logic              pair_ready,
  output logic              done,
  output logic              equal,
  output logic [DATA_W-1:0] diff_out
);

  localparam logic [LEN_W-1:0] LEN_ZERO = '0;
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

  logic              busy;
  logic [LEN_W-1:0]  left;
  logic [DATA_W-1:0] acc;
  logic              done_q;
  logic              take;

  assign pair_ready = busy & ~start;
  assign take       = pair_valid & pair_ready;
  assign done       = done_q;
  assign diff_out   = acc;
  assign equal      = ~|acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left   <= LEN_ZERO;
      acc    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        acc    <= '0;
        left   <= length;
        busy   <= (length != LEN_ZERO);
        done_q <= (length == LEN_ZERO);
      end else if (take) begin
        acc  <= acc | (a_byte ^ b_byte);
        left <= left - LEN_ONE;
        if (left == LEN_ONE) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && (length != LEN_ZERO) |=> pair_ready && (diff_out == '0));

  // R3
  accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && pair_ready |=>
      diff_out == ($past(diff_out) | ($past(a_byte) ^ $past(b_byte))));

  // R5
  done_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pair_ready);

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && (length == LEN_ZERO) |=> done && equal);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_ready && !start |=> $stable(diff_out) && !done);

  // R8
  restart_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !pair_ready);

endmodule

// File: tb/tb_ct_buf_compare.sv
`timescale 1ns/1ps
module tb_ct_buf_compare;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pair_valid = 1'b0;
  logic [7:0] length = '0, a_byte = '0, b_byte = '0;
  logic pair_ready, done, equal;
  logic [7:0] diff_out;
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ct_buf_compare #(.DATA_W(8), .LEN_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .length(length),
    .pair_valid(pair_valid), .a_byte(a_byte), .b_byte(b_byte),
    .pair_ready(pair_ready), .done(done), .equal(equal), .diff_out(diff_out));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      finish_run();
    end
  end

  task automatic do_start(input int n);
    @(negedge clk);
    start = 1'b1; length = 8'(n); pair_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Back-to-back compare; p1/p2 are mismatch positions (-1 = none)
  task automatic run_case(input int n, input int p1, input int p2, input int seed);
    logic [7:0] exp_diff = 8'h00;
    do_start(n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] av, m;
      av = 8'(i * 37 + n * 11 + seed);
      m  = 8'h00;
      if (i == p1) m = m | 8'(1 << ((seed + i) % 8));
      if (i == p2) m = m | 8'h81;
      exp_diff = exp_diff | m;
      a_byte = av; b_byte = av ^ m; pair_valid = 1'b1;
      #0.1;
      chk("R4 ready held", pair_ready, 1);
      chk("R5 no early done", done, 0);
      @(negedge clk);
    end
    pair_valid = 1'b0;
    chk("R5 done timing", done, 1);
    chk("R6 diff", diff_out, exp_diff);
    chk("R6 equal", equal, exp_diff == 0);
    if (n == 0) chk("R7 zero len diff", diff_out, 0);
    @(negedge clk);
    chk("R5 done pulse", done, 0);
  endtask

  initial begin
    @(negedge clk);
    chk("R1 done reset", done, 0);
    chk("R1 ready reset", pair_ready, 0);
    chk("R1 diff reset", diff_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", done, 0);

    for (int n = 0; n <= 6; n++)
      for (int p = -1; p < n; p++) begin
        run_case(n, p, -1, n + p * 3);
        if (p >= 0 && n > 1) run_case(n, p, n - 1, n * 5 + p);
      end

    // Gapped valid: idle cycles between accepted pairs
    do_start(4);
    chk("R2 cleared", diff_out, 0);
    for (int i = 0; i < 4; i++) begin
      pair_valid = 1'b0; a_byte = 8'hFF; b_byte = 8'h00;
      @(negedge clk);
      chk("R4 ready during gap", pair_ready, 1);
      pair_valid = 1'b1; a_byte = 8'(i); b_byte = (i == 1) ? 8'h11 : 8'(i);
      @(negedge clk);
    end
    pair_valid = 1'b0;
    chk("R5 done gapped", done, 1);
    chk("R3 gapped diff", diff_out, 8'h10);
    chk("R6 gapped equal", equal, 0);

    // Restart abandons a mismatching comparison
    do_start(5);
    for (int i = 0; i < 2; i++) begin
      pair_valid = 1'b1; a_byte = 8'hA5; b_byte = 8'h5A;
      @(negedge clk);
    end
    chk("R3 partial diff", diff_out, 8'hFF);
    pair_valid = 1'b0;
    start = 1'b1; length = 8'd3;
    #0.1;
    chk("R8 ready low on start", pair_ready, 0);
    @(negedge clk);
    start = 1'b0;
    chk("R8 cleared on restart", diff_out, 0);
    for (int i = 0; i < 3; i++) begin
      pair_valid = 1'b1; a_byte = 8'(i + 7); b_byte = 8'(i + 7);
      @(negedge clk);
    end
    pair_valid = 1'b0;
    chk("R8 restart done", done, 1);
    chk("R8 restart equal", equal, 1);

    // Idle: offered pairs ignored
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      pair_valid = 1'b1; a_byte = 8'hF0; b_byte = 8'h0F;
      #0.1;
      chk("R9 idle ready", pair_ready, 0);
      @(negedge clk);
      chk("R9 idle diff held", diff_out, 0);
      chk("R9 idle no done", done, 0);
    end
    pair_valid = 1'b0;

    // Zero length right after a mismatch clears the difference
    run_case(3, 0, -1, 9);
    run_case(0, -1, -1, 0);
    chk("R7 zero len equal", equal, 1);

    finish_run();
  end
endmodule